// File: doc/BRIEF.md
# Peripheral Bus Register Slave

This block sits on a simple two-phase peripheral bus and exposes eight 32-bit memory-mapped registers. Each transfer is a SETUP cycle (select high, enable low) followed by an ENABLE cycle (both high). The slave adds no wait states. Read data comes from a combinational path and is valid during the ENABLE cycle. A write lands on the clock edge that closes ENABLE.

Six of the registers are plain read/write storage. One register mirrors a 32-bit status input and cannot be written. One register holds sticky event flags: an event input sets a flag, and software clears it by writing a one to that bit. The slave handles transfers issued back to back, with select held high across them, and writes exactly once per ENABLE cycle.

Top module: `pbus_regslave`

## Requirements
- R1: A write takes effect on the rising edge that ends a cycle in which select, enable and write are all high. The register holds the write data sampled in that ENABLE cycle, and the next read returns it.
- R2: Nothing changes in the register state during a SETUP cycle, during a read transfer, or while select is low. Write data driven during SETUP is never stored.
- R3: The register index is address bits [4:2]. Index 0 to 5 select the read/write registers (byte offsets 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14), index 6 (0x18) selects status, and index 7 (0x1C) selects flags. Address bits [1:0] and all bits above bit 4 are ignored.
- R4: While select is high, `rdata` shows the indexed register. While select is low, `rdata` is zero.
- R5: The status register reads the current value of `status_in`, and a write to index 6 has no effect.
- R6: A flag bit is set on the edge after its `event_in` bit is high, and it stays set until it is cleared.
- R7: A write to index 7 clears every flag bit written as 1 and leaves bits written as 0 unchanged. If an event and a clear hit the same bit in the same cycle, the bit ends up set.
- R8: After reset, the six read/write registers and all flags read zero.
- R9: In back-to-back transfers with select held high, each transfer writes once to its own address, and no cycle in which select is merely held counts as a new access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| psel | input | 1 | Slave select |
| penable | input | 1 | Second-phase (ENABLE) indicator |
| pwrite | input | 1 | 1 for a write transfer, 0 for a read |
| paddr | input | ADDR_W | Byte address; bits [4:2] pick the register |
| pwdata | input | 32 | Write data, valid during ENABLE |
| rdata | output | 32 | Read data, zero while not selected |
| status_in | input | 32 | Live value shown at the status register |
| event_in | input | 32 | Per-bit flag set requests |

## Verification
The bench runs isolated single transfers with idle cycles between them, and also chains of back-to-back transfers with select held high. These two patterns separate a slave that decodes each ENABLE correctly from one that counts a held select as a fresh access. Every write drives the bitwise inverse of its real data during SETUP, so a slave that commits in the wrong phase stores the wrong word. Aliased addresses, with low bits set or bit 5 set, show whether decoding uses only bits [4:2]. Event pulses, partial clears, and a clear colliding with an event on the same bit show whether flags are sticky, whether the clear touches only the written bits, and which side wins a collision.

// File: rtl/pbus_regslave_pkg.sv
package pbus_regslave_pkg;
  localparam int DATA_W     = 32;
  localparam int NUM_REGS   = 8;
  localparam int IDX_W      = $clog2(NUM_REGS);
  localparam int IDX_LSB    = 2;
  localparam int NUM_RW     = 6;
  localparam int STATUS_IDX = 6;
  localparam int FLAG_IDX   = 7;

  typedef logic [DATA_W-1:0] word_t;
  typedef logic [IDX_W-1:0]  idx_t;
endpackage

// File: rtl/pbus_rst_sync.sv
module pbus_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pbus_decode.sv
module pbus_decode
  import pbus_regslave_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel,
  input  logic                en,
  input  logic                wr,
  input  idx_t                idx,
  output logic [NUM_REGS-1:0] wr_stb
);
  logic access_wr;

  always_comb begin
    access_wr = sel & en & wr;
    wr_stb    = '0;
    if (access_wr) wr_stb[idx] = 1'b1;
  end

  // R9: a write strobe never lasts two cycles; each ENABLE is followed by a SETUP or idle
  a_r9_no_double_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_stb) |=> !(|wr_stb));

  // R3: at most one register is addressed per write
  a_r3_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_stb));
endmodule

// File: rtl/pbus_rw_bank.sv
module pbus_rw_bank #(
  parameter int N = 6,
  parameter int W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        wr_stb,
  input  logic [W-1:0]        wdata,
  output logic [N-1:0][W-1:0] q
);
  logic [N-1:0][W-1:0] q_nxt;

  for (genvar g = 0; g < N; g++) begin : g_reg
    always_comb begin
      q_nxt[g] = q[g];
      if (wr_stb[g]) q_nxt[g] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         q[g] <= '0;
      else if (wr_stb[g]) q[g] <= q_nxt[g];
    end

    // R1: the strobed register holds the data present in the ENABLE cycle
    a_r1_write_commit: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb[g] |=> (q[g] == $past(wdata)));
  end
endmodule

// File: rtl/pbus_w1c_flags.sv
module pbus_w1c_flags #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_stb,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] evt,
  output logic [W-1:0] q
);
  logic [W-1:0] clr_mask;
  logic [W-1:0] q_nxt;
  logic         upd;

  always_comb begin
    clr_mask = clr_stb ? wdata : '0;
    q_nxt    = (q & ~clr_mask) | evt;
    upd      = clr_stb | (|evt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (upd) q <= q_nxt;
  end

  // R6: every bit requested by an event is set on the next edge
  a_r6_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((q & $past(evt)) == $past(evt)));

  // R6: without a clear, set bits stay set
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_stb |=> ((q & $past(q)) == $past(q)));

  // R7: cleared bits drop unless an event hit them in the same cycle
  a_r7_clear_ones: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> ((q & $past(wdata) & ~$past(evt)) == '0));
endmodule

// File: rtl/pbus_read_mux.sv
module pbus_read_mux
  import pbus_regslave_pkg::*;
(
  input  logic                          sel,
  input  idx_t                          idx,
  input  logic [NUM_RW-1:0][DATA_W-1:0] rw_q,
  input  word_t                         status,
  input  word_t                         flags,
  output word_t                         rdata
);
  word_t picked;

  always_comb begin
    if (int'(idx) < NUM_RW)           picked = rw_q[idx];
    else if (int'(idx) == STATUS_IDX) picked = status;
    else                              picked = flags;
    rdata = sel ? picked : '0;
  end
endmodule

// File: rtl/pbus_regslave.sv
module pbus_regslave
  import pbus_regslave_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       rdata,
  input  logic [31:0]       status_in,
  input  logic [31:0]       event_in
);
  logic                          rst_i_n;
  idx_t                          idx;
  logic [NUM_REGS-1:0]           wr_stb;
  logic [NUM_RW-1:0][DATA_W-1:0] rw_q;
  word_t                         flags_q;
  logic                          unused_addr_bits;

  assign idx              = paddr[IDX_LSB +: IDX_W];
  assign unused_addr_bits = ^{paddr[ADDR_W-1:IDX_LSB+IDX_W], paddr[IDX_LSB-1:0], wr_stb[STATUS_IDX]};

  pbus_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  pbus_decode u_dec (
    .clk(clk), .rst_n(rst_i_n), .sel(psel), .en(penable), .wr(pwrite),
    .idx(idx), .wr_stb(wr_stb)
  );

  pbus_rw_bank #(.N(NUM_RW), .W(DATA_W)) u_bank (
    .clk(clk), .rst_n(rst_i_n), .wr_stb(wr_stb[NUM_RW-1:0]),
    .wdata(pwdata), .q(rw_q)
  );

  pbus_w1c_flags #(.W(DATA_W)) u_flags (
    .clk(clk), .rst_n(rst_i_n), .clr_stb(wr_stb[FLAG_IDX]),
    .wdata(pwdata), .evt(event_in), .q(flags_q)
  );

  pbus_read_mux u_rmux (
    .sel(psel), .idx(idx), .rw_q(rw_q), .status(status_in),
    .flags(flags_q), .rdata(rdata)
  );

  // R2: storage is untouched by any cycle that is not a write ENABLE
  a_r2_no_stray_write: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(psel && penable && pwrite) |=> $stable(rw_q));

  // R5: the status location shows the live input
  a_r5_status_live: assert property (@(posedge clk) disable iff (!rst_i_n)
    (psel && (int'(idx) == STATUS_IDX)) |-> (rdata == status_in));

  // R4: an unselected slave returns zero
  a_r4_idle_zero: assert property (@(posedge clk) disable iff (!rst_i_n)
    !psel |-> (rdata == '0));
endmodule

// File: tb/pbus_regslave_test.sv
module pbus_regslave_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 12;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              psel, penable, pwrite;
  logic [ADDR_W-1:0] paddr;
  logic [31:0]       pwdata, rdata, status_in, event_in;

  pbus_regslave #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .rdata(rdata),
    .status_in(status_in), .event_in(event_in)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] m_rw [6];
  logic [31:0] m_flag;
  logic [31:0] q_exp [$];
  string       q_tag [$];

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_of(input logic [2:0] ix);
    if (ix < 3'd6)       return m_rw[ix];
    else if (ix == 3'd6) return status_in;
    else                 return m_flag;
  endfunction

  // Leaves the bus just after the edge that closed ENABLE, select still high.
  task automatic xfer(input bit w, input logic [ADDR_W-1:0] a, input logic [31:0] d,
                      input logic [31:0] ev, input string tag);
    psel = 1'b1; penable = 1'b0; pwrite = w; paddr = a; pwdata = ~d;
    if (!w) begin
      q_exp.push_back(model_of(a[4:2]));
      q_tag.push_back(tag);
    end
    @(posedge clk); #1;
    penable = 1'b1; pwdata = d; event_in = ev;
    @(posedge clk); #1;
    penable = 1'b0; event_in = '0;
    if (w) begin
      if (a[4:2] < 3'd6)       m_rw[a[4:2]] = d;
      else if (a[4:2] == 3'd7) m_flag = m_flag & ~d;
    end
    m_flag = m_flag | ev;
  endtask

  task automatic idle();
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    @(negedge clk);
    check(rdata, 32'h0, "R4 idle read data");
    @(posedge clk); #1;
  endtask

  task automatic pulse_evt(input logic [31:0] ev);
    event_in = ev;
    @(posedge clk); #1;
    event_in = '0;
    m_flag = m_flag | ev;
  endtask

  // Scoreboard monitor: compares each read in its ENABLE cycle.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && psel && penable && !pwrite) begin
        if (q_exp.size() == 0) begin
          check(rdata, 32'hx, "R4 unexpected read");
        end else begin
          logic [31:0] e;
          string t;
          e = q_exp.pop_front();
          t = q_tag.pop_front();
          check(rdata, e, t);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0;
    status_in = 32'hC0DE_0001; event_in = '0;
    for (int i = 0; i < 6; i++) m_rw[i] = '0;
    m_flag = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;

    // R8: reset values of every location
    for (int i = 0; i < 8; i++) begin
      xfer(0, 12'(i*4), 0, 0, "R8 reset value");
      idle();
    end

    // R1: isolated writes then reads
    for (int i = 0; i < 6; i++) begin
      xfer(1, 12'(i*4), 32'h1111_0000 * (i+1) ^ 32'h0000_A5A5, 0, "R1 write");
      idle();
    end
    for (int i = 0; i < 6; i++) begin
      xfer(0, 12'(i*4), 0, 0, "R1 readback");
      idle();
    end

    // R9: back-to-back writes and reads with select held high
    xfer(1, 12'h000, 32'hDEAD_0000, 0, "R9 b2b write");
    xfer(1, 12'h004, 32'hDEAD_0001, 0, "R9 b2b write");
    xfer(1, 12'h008, 32'hDEAD_0002, 0, "R9 b2b write");
    xfer(0, 12'h000, 0, 0, "R9 b2b read");
    xfer(0, 12'h004, 0, 0, "R9 b2b read");
    xfer(0, 12'h008, 0, 0, "R9 b2b read");
    xfer(0, 12'h00C, 0, 0, "R9 b2b read untouched");
    idle();

    // R2: reads with data on the bus leave storage alone
    pwdata = 32'hFFFF_FFFF;
    xfer(0, 12'h010, 32'hFFFF_FFFF, 0, "R2 read no side effect");
    xfer(0, 12'h010, 0, 0, "R2 read repeat");
    idle();

    // R3: low bits and high bits ignored
    xfer(1, 12'h00B, 32'h3333_CAFE, 0, "R3 write low bits set");
    idle();
    xfer(0, 12'h028, 0, 0, "R3 read via bit5 alias");
    xfer(0, 12'hFE9, 0, 0, "R3 read via high alias");
    idle();

    // R5: status read-only and live
    xfer(1, 12'h018, 32'h1234_5678, 0, "R5 write status");
    xfer(0, 12'h018, 0, 0, "R5 status after write");
    idle();
    status_in = 32'h0BAD_F00D;
    xfer(0, 12'h018, 0, 0, "R5 status live");
    idle();

    // R6: sticky event flags
    pulse_evt(32'h0000_00F0);
    pulse_evt(32'h8000_0001);
    xfer(0, 12'h01C, 0, 0, "R6 flags set and sticky");
    idle();

    // R7: partial clear, then clear colliding with event
    xfer(1, 12'h01C, 32'h0000_0030, 0, "R7 clear two bits");
    xfer(0, 12'h01C, 0, 0, "R7 after partial clear");
    xfer(1, 12'h01C, 32'h8000_0000, 32'h8000_0000, "R7 clear vs event");
    xfer(0, 12'h01C, 0, 0, "R7 event wins");
    xfer(1, 12'h01C, 32'hFFFF_FFFF, 0, "R7 clear all");
    xfer(0, 12'h01C, 0, 0, "R7 all cleared");
    idle();

    repeat (4) @(posedge clk);
    if (q_exp.size() != 0) check(32'(q_exp.size()), 32'h0, "R4 reads not seen");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule